// File: doc/BRIEF.md
# Receive Buffer with Per-Character Error Tags

This block is the receive-side character store of a 16550-class serial port. The receive shifter hands it one character at a time, together with that character's parity-error, framing-error and break indications. Reads of the receive data register pop the oldest character. Each stored character keeps its own error tags, so the line-status error bits presented to software always describe the character at the head of the buffer, which may be older than the newest arrival.

With the buffer enabled it holds up to sixteen characters. With the buffer disabled it acts as a single holding register, and a new character replaces an unread one. A sticky overrun flag records lost characters until line status is read. A buffer-reset command, or any change of the enable input, empties the store.

Top module: `rx_err_fifo`

## Requirements
- R1: `data_ready` is 1 exactly when at least one character is stored; in buffered mode (`fifo_en`=1) up to 16 characters are stored.
- R2: A `rd_pop` pulse while not empty removes the oldest character. Characters leave in arrival order. A `rd_pop` pulse while empty has no effect.
- R3: `head_data`, `head_perr`, `head_ferr` and `head_brk` show the byte and the error tags of the oldest stored character, which were captured with that character when it was written. All four read 0 while the buffer is empty.
- R4: In buffered mode, a write (`wr_valid`=1) with 16 characters stored and no pop in the same cycle is discarded. The stored characters are kept and `overrun` is set in the next cycle.
- R5: A write and a pop in the same cycle with the buffer full both take effect, and `overrun` is not set.
- R6: In single-register mode (`fifo_en`=0) at most one character is held. A write while one is held and no pop occurs in that cycle replaces it and sets `overrun`.
- R7: Once set, `overrun` stays 1 until a cycle with `lsr_read`=1 in which no new overrun occurs. If both happen in one cycle, the flag stays set.
- R8: A cycle with `fifo_clr`=1, or a cycle in which `fifo_en` differs from its value in the previous cycle, empties the buffer. Any write or pop in that cycle is ignored, and `overrun` keeps its value, apart from a clear by `lsr_read`.
- R9: After a synchronous active-low reset the buffer is empty, `overrun` is 0 and the remembered enable value is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fifo_en | input | 1 | 1 = 16-entry buffered mode, 0 = single holding register |
| fifo_clr | input | 1 | Buffer reset command, one-cycle pulse |
| wr_valid | input | 1 | A received character is offered this cycle |
| wr_data | input | 8 | Received byte |
| wr_perr | input | 1 | Parity error of the offered character |
| wr_ferr | input | 1 | Framing error of the offered character |
| wr_brk | input | 1 | Break indication of the offered character |
| rd_pop | input | 1 | Receive data register read; removes the head |
| lsr_read | input | 1 | Line status read; clears the overrun flag |
| head_data | output | 8 | Oldest stored byte |
| head_perr | output | 1 | Parity tag of the oldest character |
| head_ferr | output | 1 | Framing tag of the oldest character |
| head_brk | output | 1 | Break tag of the oldest character |
| data_ready | output | 1 | At least one character stored |
| overrun | output | 1 | Sticky lost-character flag |

## Verification
The assertions assume that the control inputs are known (never X) after reset. They also assume that `rd_pop` and `lsr_read` are single-cycle strobes, which any value of the other inputs leaves legal. The stimulus draws every control input from a seeded generator each cycle. It keeps enable changes and buffer-reset commands rare, so that runs of writes can fill the buffer and reach the full and overrun cases. Directed sequences cover the boundaries that random traffic reaches only seldom: a full buffer, a write and a pop together on a full buffer, and a replacement in single-register mode.

// File: rtl/rx_fifo_pkg.sv
// Shared types for the receive buffer: one stored character with its tags.
// Assumes 8-bit characters, as the receive shifter delivers.
package rx_fifo_pkg;
    localparam int CHAR_W = 8;

    typedef struct packed {
        logic              brk;
        logic              ferr;
        logic              perr;
        logic [CHAR_W-1:0] data;
    } rx_entry_t;
endpackage

// File: rtl/rx_fifo_ctrl.sv
// Pointer and occupancy control for the receive buffer.
// Decides, each cycle, whether a write is accepted, replaces the head or is
// dropped. It also raises the overrun event and handles flushes caused by
// the reset command or by a change of the enable input.
// Assumes DEPTH is a power of two.
module rx_fifo_ctrl #(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fifo_en,
    input  logic          fifo_clr,
    input  logic          wr_valid,
    input  logic          rd_pop,
    output logic          st_we,
    output logic [AW-1:0] st_waddr,
    output logic [AW-1:0] rd_ptr,
    output logic [CW-1:0] count,
    output logic          flush,
    output logic          ovr_set
);
    logic          en_q;
    logic [AW-1:0] wr_ptr;
    logic          pop_ok;
    logic          at_cap;
    logic          push_ok;
    logic          replace;

    // Classify this cycle's write and pop against the active capacity.
    always_comb begin
        flush   = fifo_clr || (fifo_en != en_q);
        pop_ok  = !flush && rd_pop && (count != '0);
        at_cap  = fifo_en ? (count == CW'(DEPTH)) : (count == CW'(1));
        push_ok = !flush && wr_valid && (!at_cap || pop_ok);
        replace = !flush && wr_valid && at_cap && !pop_ok && !fifo_en;
        ovr_set = !flush && wr_valid && at_cap && !pop_ok;
        st_we   = push_ok || replace;
        st_waddr = replace ? rd_ptr : wr_ptr;
    end

    // Track the enable value seen in the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= fifo_en;
    end

    // Advance the pointers and the occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= wr_ptr + AW'(1);
            if (pop_ok)  rd_ptr <= rd_ptr + AW'(1);
            if (push_ok && !pop_ok)      count <= count + CW'(1);
            else if (pop_ok && !push_ok) count <= count - CW'(1);
        end
    end
endmodule

// File: rtl/rx_fifo_store.sv
// Character storage: one write port and one asynchronous read port.
// The entries need no reset, because the head is masked while empty.
module rx_fifo_store #(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic                  clk,
    input  logic                  we,
    input  logic [AW-1:0]         waddr,
    input  rx_fifo_pkg::rx_entry_t wentry,
    input  logic [AW-1:0]         raddr,
    output rx_fifo_pkg::rx_entry_t rentry
);
    rx_fifo_pkg::rx_entry_t mem [DEPTH];

    // Capture an accepted or replacing character.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wentry;
    end

    // Present the addressed entry.
    always_comb rentry = mem[raddr];
endmodule

// File: rtl/rx_ovr_flag.sv
// Sticky overrun flag: a set event wins over a clear by a line-status read.
module rx_ovr_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_ev,
    input  logic clr_ev,
    output logic flag
);
    // Hold the flag until a line-status read that has no new set event.
    always_ff @(posedge clk) begin
        if (!rst_n)      flag <= 1'b0;
        else if (set_ev) flag <= 1'b1;
        else if (clr_ev) flag <= 1'b0;
    end
endmodule

// File: rtl/rx_err_fifo.sv
// Receive buffer with per-character error tags (top).
// Holds up to DEPTH characters in buffered mode, or one in single-register
// mode. It presents the head character and that character's own tags.
// Assumes rd_pop and lsr_read are single-cycle register-access strobes.
module rx_err_fifo #(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fifo_en,
    input  logic       fifo_clr,
    input  logic       wr_valid,
    input  logic [7:0] wr_data,
    input  logic       wr_perr,
    input  logic       wr_ferr,
    input  logic       wr_brk,
    input  logic       rd_pop,
    input  logic       lsr_read,
    output logic [7:0] head_data,
    output logic       head_perr,
    output logic       head_ferr,
    output logic       head_brk,
    output logic       data_ready,
    output logic       overrun
);
    import rx_fifo_pkg::*;

    logic          st_we;
    logic [AW-1:0] st_waddr;
    logic [AW-1:0] rd_ptr;
    logic [CW-1:0] count;
    logic          flush;
    logic          ovr_set;
    rx_entry_t     wentry;
    rx_entry_t     rentry;
    rx_entry_t     head;

    // Bundle the incoming character with its tags.
    always_comb wentry = '{brk: wr_brk, ferr: wr_ferr, perr: wr_perr, data: wr_data};

    rx_fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .fifo_clr(fifo_clr),
        .wr_valid(wr_valid), .rd_pop(rd_pop), .st_we(st_we),
        .st_waddr(st_waddr), .rd_ptr(rd_ptr), .count(count),
        .flush(flush), .ovr_set(ovr_set)
    );

    rx_fifo_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .we(st_we), .waddr(st_waddr), .wentry(wentry),
        .raddr(rd_ptr), .rentry(rentry)
    );

    rx_ovr_flag u_ovr (
        .clk(clk), .rst_n(rst_n), .set_ev(ovr_set), .clr_ev(lsr_read),
        .flag(overrun)
    );

    // Mask the head to zero while nothing is stored.
    always_comb begin
        data_ready = (count != '0);
        head       = data_ready ? rentry : '0;
        head_data  = head.data;
        head_perr  = head.perr;
        head_ferr  = head.ferr;
        head_brk   = head.brk;
    end
endmodule

// File: rtl/rx_err_fifo_chk.sv
// Property checker for the receive buffer, bound into the top module.
module rx_err_fifo_chk #(
    parameter int DEPTH = 16,
    localparam int CW = $clog2(DEPTH) + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          fifo_en,
    input logic          fifo_clr,
    input logic          wr_valid,
    input logic          rd_pop,
    input logic          lsr_read,
    input logic          data_ready,
    input logic          overrun,
    input logic [CW-1:0] count,
    input logic          flush,
    input logic          ovr_set
);
    // R1
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    // R8
    clr_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_clr |=> !data_ready);

    // R4
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_en && !flush && count == CW'(DEPTH) && wr_valid && !rd_pop)
        |=> (overrun && count == CW'(DEPTH)));

    // R7
    ovr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lsr_read && !ovr_set) |=> !overrun);

    // R6
    single_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_en && !flush) |=> (count <= CW'(1)));

    // R2
    pop_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_pop && data_ready && !wr_valid && !flush)
        |=> (count == $past(count) - CW'(1)));
endmodule

bind rx_err_fifo rx_err_fifo_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .fifo_clr(fifo_clr),
    .wr_valid(wr_valid), .rd_pop(rd_pop), .lsr_read(lsr_read),
    .data_ready(data_ready), .overrun(overrun), .count(count),
    .flush(flush), .ovr_set(ovr_set)
);

// File: tb/tb_rx_err_fifo.sv
`timescale 1ns/1ps
module tb_rx_err_fifo;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fifo_en = 1'b0, fifo_clr = 1'b0, wr_valid = 1'b0;
    logic [7:0] wr_data = '0;
    logic       wr_perr = 1'b0, wr_ferr = 1'b0, wr_brk = 1'b0;
    logic       rd_pop = 1'b0, lsr_read = 1'b0;
    logic [7:0] head_data;
    logic       head_perr, head_ferr, head_brk, data_ready, overrun;

    int checks = 0;
    int fails  = 0;
    string phase = "reset";

    // reference state
    logic [10:0] mq[$];
    logic        m_en_q = 1'b0;
    logic        m_ovr  = 1'b0;

    always #4 clk = ~clk;

    rx_err_fifo dut (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .fifo_clr(fifo_clr),
        .wr_valid(wr_valid), .wr_data(wr_data), .wr_perr(wr_perr),
        .wr_ferr(wr_ferr), .wr_brk(wr_brk), .rd_pop(rd_pop),
        .lsr_read(lsr_read), .head_data(head_data), .head_perr(head_perr),
        .head_ferr(head_ferr), .head_brk(head_brk),
        .data_ready(data_ready), .overrun(overrun)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s [%s] act=%h exp=%h", req, phase, act, exp);
        end
    endtask

    function automatic logic [10:0] exp_head();
        return (mq.size() == 0) ? 11'h0 : mq[0];
    endfunction

    task automatic compare();
        logic [10:0] act_h;
        act_h = {head_brk, head_ferr, head_perr, head_data};
        check(data_ready == (mq.size() != 0), "R1", 32'(data_ready), 32'(mq.size() != 0));
        check(act_h == exp_head(), "R3", 32'(act_h), 32'(exp_head()));
        check(overrun == m_ovr, "R7", 32'(overrun), 32'(m_ovr));
    endtask

    // Model of one clock edge, written from the requirements.
    task automatic model(input logic en, clr, wv, input logic [10:0] w, input logic pop, lsr);
        bit fl, popok, full, ovs;
        int cap;
        fl = clr || (en != m_en_q);
        m_en_q = en;
        ovs = 0;
        if (fl) mq.delete();
        else begin
            cap   = en ? 16 : 1;
            full  = (mq.size() >= cap);
            popok = pop && (mq.size() > 0);
            if (popok) void'(mq.pop_front());
            if (wv) begin
                if (!full || popok) mq.push_back(w);
                else if (en) ovs = 1;
                else begin mq[0] = w; ovs = 1; end
            end
        end
        if (ovs) m_ovr = 1'b1;
        else if (lsr) m_ovr = 1'b0;
    endtask

    task automatic step(input logic en, clr, wv, input logic [10:0] w, input logic pop, lsr);
        @(negedge clk);
        compare();
        fifo_en = en; fifo_clr = clr; wr_valid = wv;
        {wr_brk, wr_ferr, wr_perr, wr_data} = w;
        rd_pop = pop; lsr_read = lsr;
        model(en, clr, wv, w, pop, lsr);
    endtask

    task automatic idle(input logic en);
        step(en, 0, 0, 11'h0, 0, 0);
    endtask

    initial begin
        #(200000 * 8);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: empty, no overrun after reset
        check(data_ready == 1'b0, "R9", 32'(data_ready), 0);
        check(overrun == 1'b0, "R9", 32'(overrun), 0);

        phase = "R8 enable buffered";
        idle(1); idle(1);
        phase = "R4 fill and drop";
        for (int i = 0; i < 16; i++) step(1, 0, 1, {3'(i), 8'(8'h40 + i)}, 0, 0);
        step(1, 0, 1, 11'h7AA, 0, 0);
        idle(1);
        phase = "R5 full write with pop";
        step(1, 0, 1, 11'h1C3, 1, 1);
        idle(1);
        phase = "R2 drain in order";
        for (int i = 0; i < 18; i++) step(1, 0, 0, 11'h0, 1, 0);
        idle(1);
        phase = "R8 switch to single";
        step(1, 0, 1, 11'h255, 0, 0);
        step(0, 0, 1, 11'h266, 0, 0);
        idle(0);
        phase = "R6 single overwrite";
        step(0, 0, 1, 11'h311, 0, 1);
        step(0, 0, 1, 11'h422, 0, 0);
        idle(0);
        step(0, 0, 1, 11'h533, 1, 1);
        idle(0);
        phase = "R8 reset command";
        step(0, 1, 1, 11'h644, 0, 0);
        idle(0);

        phase = "random";
        for (int n = 0; n < 6000; n++) begin
            logic en, clr, wv, pop, lsr;
            int pr;
            pr  = (n % 1000 < 500) ? 20 : 60;
            en  = (($urandom % 300) == 0) ? ~fifo_en : fifo_en;
            clr = (($urandom % 400) == 0);
            wv  = (($urandom % 100) < 50);
            pop = (($urandom % 100) < pr);
            lsr = (($urandom % 100) < 10);
            step(en, clr, wv, 11'($urandom), pop, lsr);
        end
        @(negedge clk);
        compare();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule